// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is one input-capture channel that sits beside a free-running 16-bit timer. An edge qualifier outside the block turns a valid pin transition into a single-cycle capture strobe. On that strobe the channel copies the current timer count into its capture register. Behind the capture register there is a one-deep holding register, so software has a second slot to read from.

The mode bit decides how the holding register is filled:

- **Latch mode (mode = 1):** the capture value moves into the holding register when any of three latch requests arrives. These are the modulus counter reaching zero, a zero written to the modulus counter, or a software latch command.
- **Queue mode (mode = 0):** each new capture pushes the previous capture value into the holding register.

Each register has a full flag. A register is empty after it is read or after its value moves onward. A per-channel no-overwrite bit stops any event from writing a register that is still full. This keeps unread data safe.

Top module: `capture_hold_channel`

## Requirements
- R1: A synchronous active-high reset clears both registers to 0 and clears both full flags, one clock edge after the reset is sampled.
- R2: A capture strobe that finds the capture register empty stores the timer count into it and sets its full flag, visible after the next clock edge.
- R3: With no-overwrite clear, a capture strobe replaces the capture register contents even when that register is full and unread.
- R4: In latch mode with no-overwrite set, a capture strobe that finds the capture register full, with no read and no latch in the same cycle, leaves the register and its flag unchanged. After a read empties the register, a capture is accepted again.
- R5: When a capture and a capture-register read fall in the same cycle, the output shows the old value during that cycle. After the edge the register holds the new capture and stays full.
- R6: In latch mode, a latch request from any of the three latch inputs moves a full capture register into the holding register. The capture flag clears and the holding flag sets. A latch request while the capture register is empty changes nothing.
- R7: In latch mode with no-overwrite clear, a latch request overwrites a full holding register.
- R8: In latch mode with no-overwrite set, a latch request that finds the holding register full (and not being read) is blocked. Both registers and flags stay unchanged. Once the holding register is read, the next latch request succeeds.
- R9: In queue mode, a capture strobe while the capture register is full and the holding register may be written moves the old capture value into the holding register and stores the new count. Both flags are then set. If the capture register is empty, no transfer takes place.
- R10: In queue mode with no-overwrite set, a capture strobe that finds both registers full (no read that cycle) is dropped. Both registers stay unchanged.
- R11: In queue mode, the latch request inputs have no effect.
- R12: A holding-register read clears the holding full flag but leaves its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | 16 | Free-running timer count |
| cap_stb | input | 1 | Qualified edge strobe, one cycle per edge |
| lat_mod_zero | input | 1 | Latch request: modulus counter reached zero |
| lat_mod_wr0 | input | 1 | Latch request: zero written to modulus counter |
| lat_sw | input | 1 | Latch request: software command |
| rd_cap | input | 1 | Capture register read strobe |
| rd_hold | input | 1 | Holding register read strobe |
| latch_mode | input | 1 | 1 = latch mode, 0 = queue mode |
| no_ovw | input | 1 | 1 = protect full registers from being overwritten |
| cap_q | output | 16 | Capture register contents |
| hold_q | output | 16 | Holding register contents |
| cap_full | output | 1 | Capture register holds unread data |
| hold_full | output | 1 | Holding register holds unread data |

## Verification
All state in this block is visible directly at the ports: the two registers and their full flags are outputs. A wrong internal decision therefore shows up one clock edge after the event that caused it. A missed transfer, a stuck flag or a protection that fails to hold appears as a wrong register value or flag right after that edge. The corner cases that need checking are where events overlap: reads in the same cycle as captures, latches or queue pushes into a full holding register, and latch requests while the capture register is empty.

// File: rtl/capture_hold_channel.sv
module capture_hold_channel #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tmr_cnt,
  input  logic          cap_stb,
  input  logic          lat_mod_zero,
  input  logic          lat_mod_wr0,
  input  logic          lat_sw,
  input  logic          rd_cap,
  input  logic          rd_hold,
  input  logic          latch_mode,
  input  logic          no_ovw,
  output logic [TW-1:0] cap_q,
  output logic [TW-1:0] hold_q,
  output logic          cap_full,
  output logic          hold_full
);

  logic [TW-1:0] cap_r, hold_r;
  logic          cap_f, hold_f;

  wire lat_any   = lat_mod_zero | lat_mod_wr0 | lat_sw;
  wire hold_room = !no_ovw || !hold_f || rd_hold;
  wire xfer_evt  = latch_mode ? lat_any : cap_stb;
  wire xfer      = cap_f && hold_room && xfer_evt;
  wire cap_room  = !no_ovw || !cap_f || rd_cap || xfer;
  wire cap_wr    = cap_stb && cap_room;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_r  <= '0;
      hold_r <= '0;
      cap_f  <= 1'b0;
      hold_f <= 1'b0;
    end else begin
      if (xfer)   hold_r <= cap_r;
      if (cap_wr) cap_r  <= tmr_cnt;
      hold_f <= xfer | (hold_f & ~rd_hold);
      cap_f  <= cap_wr | (cap_f & ~rd_cap & ~xfer);
    end
  end

  assign cap_q     = cap_r;
  assign hold_q    = hold_r;
  assign cap_full  = cap_f;
  assign hold_full = hold_f;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cap_q == '0 && hold_q == '0 && !cap_full && !hold_full));

  a_r2_capture_empty: assert property (@(posedge clk) disable iff (rst)
    (cap_stb && !cap_full) |=> (cap_full && cap_q == $past(tmr_cnt)));

  a_r4_protect_capture: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && no_ovw && cap_full && !rd_cap && !lat_any)
      |=> ($stable(cap_q) && cap_full));

  a_r6_latch_moves: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && lat_any && cap_full && (!no_ovw || !hold_full || rd_hold))
      |=> (hold_q == $past(cap_q) && hold_full));

  a_r9_queue_push: assert property (@(posedge clk) disable iff (rst)
    (!latch_mode && cap_stb && cap_full && (!no_ovw || !hold_full || rd_hold))
      |=> (hold_q == $past(cap_q) && cap_q == $past(tmr_cnt) && hold_full && cap_full));

  a_r10_queue_drop: assert property (@(posedge clk) disable iff (rst)
    (!latch_mode && no_ovw && cap_full && hold_full && !rd_cap && !rd_hold)
      |=> ($stable(cap_q) && $stable(hold_q)));

  a_r12_read_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_hold && !lat_any && !cap_stb) |=> (!hold_full && $stable(hold_q)));

endmodule

// File: tb/capture_hold_channel_tb_top.sv
module capture_hold_channel_tb_top;

  typedef struct {
    logic [15:0] ecap;
    logic [15:0] ehold;
    logic        ecf;
    logic        ehf;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] tmr_cnt = '0;
  logic        cap_stb = 0, lat_mod_zero = 0, lat_mod_wr0 = 0, lat_sw = 0;
  logic        rd_cap = 0, rd_hold = 0, latch_mode = 1, no_ovw = 0;
  logic [15:0] cap_q, hold_q;
  logic        cap_full, hold_full;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t sb[$];

  always #2 clk = ~clk;

  capture_hold_channel dut_i (
    .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .cap_stb(cap_stb),
    .lat_mod_zero(lat_mod_zero), .lat_mod_wr0(lat_mod_wr0), .lat_sw(lat_sw),
    .rd_cap(rd_cap), .rd_hold(rd_hold), .latch_mode(latch_mode), .no_ovw(no_ovw),
    .cap_q(cap_q), .hold_q(hold_q), .cap_full(cap_full), .hold_full(hold_full)
  );

  // Driver: set inputs at negedge, queue the state expected after the next posedge.
  task automatic step(input logic r, cs, lz, lw, ls, rc, rh, lm, nov,
                      input logic [15:0] t, input logic [15:0] ec, eh,
                      input logic ecf, ehf, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; cap_stb = cs; lat_mod_zero = lz; lat_mod_wr0 = lw; lat_sw = ls;
    rd_cap = rc; rd_hold = rh; latch_mode = lm; no_ovw = nov; tmr_cnt = t;
    e.ecap = ec; e.ehold = eh; e.ecf = ecf; e.ehf = ehf; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: after each posedge, compare against the oldest expectation.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cap_q !== e.ecap || hold_q !== e.ehold || cap_full !== e.ecf || hold_full !== e.ehf) begin
        failures++;
        $display("FAIL %s: actual cap=%h hold=%h cf=%b hf=%b expected cap=%h hold=%h cf=%b hf=%b",
                 e.tag, cap_q, hold_q, cap_full, hold_full, e.ecap, e.ehold, e.ecf, e.ehf);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    //   r cs lz lw ls rc rh lm nov  t        cap      hold     cf hf
    step(1, 0, 0, 0, 0, 0, 0, 1, 0, 16'h0,  16'h0000, 16'h0000, 0, 0, "R1 reset");
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 16'h0,  16'h0000, 16'h0000, 0, 0, "R1 idle");
    // latch mode, no-overwrite clear
    step(0, 1, 0, 0, 0, 0, 0, 1, 0, 16'h1111, 16'h1111, 16'h0000, 1, 0, "R2");
    step(0, 1, 0, 0, 0, 0, 0, 1, 0, 16'h2222, 16'h2222, 16'h0000, 1, 0, "R3");
    step(0, 1, 0, 0, 0, 1, 0, 1, 0, 16'h3333, 16'h3333, 16'h0000, 1, 0, "R5");
    step(0, 0, 1, 0, 0, 0, 0, 1, 0, 16'h0,  16'h3333, 16'h3333, 0, 1, "R6 modzero");
    step(0, 0, 1, 0, 0, 0, 0, 1, 0, 16'h0,  16'h3333, 16'h3333, 0, 1, "R6 empty");
    step(0, 1, 0, 0, 0, 0, 0, 1, 0, 16'h4444, 16'h4444, 16'h3333, 1, 1, "R2");
    step(0, 0, 0, 1, 0, 0, 0, 1, 0, 16'h0,  16'h4444, 16'h4444, 0, 1, "R7 wr0");
    step(0, 1, 0, 0, 0, 0, 0, 1, 0, 16'h5555, 16'h5555, 16'h4444, 1, 1, "R2");
    step(0, 0, 0, 0, 1, 0, 0, 1, 0, 16'h0,  16'h5555, 16'h5555, 0, 1, "R6 sw");
    // latch mode, no-overwrite set
    step(0, 1, 0, 0, 0, 0, 0, 1, 1, 16'h6666, 16'h6666, 16'h5555, 1, 1, "R2");
    step(0, 1, 0, 0, 0, 0, 0, 1, 1, 16'h7777, 16'h6666, 16'h5555, 1, 1, "R4 blocked");
    step(0, 0, 0, 0, 1, 0, 0, 1, 1, 16'h0,  16'h6666, 16'h5555, 1, 1, "R8 blocked");
    step(0, 0, 0, 0, 0, 0, 1, 1, 1, 16'h0,  16'h6666, 16'h5555, 1, 0, "R12");
    step(0, 0, 0, 0, 1, 0, 0, 1, 1, 16'h0,  16'h6666, 16'h6666, 0, 1, "R8 after read");
    step(0, 1, 0, 0, 0, 0, 0, 1, 1, 16'h7777, 16'h7777, 16'h6666, 1, 1, "R2");
    step(0, 0, 0, 0, 0, 1, 0, 1, 1, 16'h0,  16'h7777, 16'h6666, 0, 1, "R4 read");
    step(0, 1, 0, 0, 0, 0, 0, 1, 1, 16'h8888, 16'h8888, 16'h6666, 1, 1, "R4 accepted");
    // queue mode, no-overwrite clear
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, 16'h0,  16'h8888, 16'h6666, 0, 0, "R12");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 16'h9999, 16'h9999, 16'h6666, 1, 0, "R9 no push");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 16'hAAAA, 16'hAAAA, 16'h9999, 1, 1, "R9 push");
    step(0, 1, 0, 0, 0, 0, 0, 0, 0, 16'hBBBB, 16'hBBBB, 16'hAAAA, 1, 1, "R9 overwrite");
    step(0, 0, 1, 1, 1, 0, 0, 0, 0, 16'h0,  16'hBBBB, 16'hAAAA, 1, 1, "R11");
    // queue mode, no-overwrite set
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, 16'hCCCC, 16'hBBBB, 16'hAAAA, 1, 1, "R10");
    step(0, 0, 0, 0, 0, 0, 1, 0, 1, 16'h0,  16'hBBBB, 16'hAAAA, 1, 0, "R12");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, 16'hCCCC, 16'hCCCC, 16'hBBBB, 1, 1, "R9 nov");
    step(0, 0, 0, 0, 0, 1, 0, 0, 1, 16'h0,  16'hCCCC, 16'hBBBB, 0, 1, "R4 read");
    step(0, 1, 0, 0, 0, 0, 0, 0, 1, 16'hDDDD, 16'hDDDD, 16'hBBBB, 1, 1, "R9 empty");
    step(0, 1, 0, 0, 0, 1, 0, 0, 1, 16'hEEEE, 16'hEEEE, 16'hBBBB, 1, 1, "R5 queue");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0,  16'h0000, 16'h0000, 0, 0, "R1 reset again");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0,  16'h0000, 16'h0000, 0, 0, "R1 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule